// File: doc/BRIEF.md
# Dual-Mode Limit Counter Timer

This block is a word-addressed counter/timer with 32-bit registers, a single tick enable and one interrupt line. A count advances by one unit on every tick while the counter runs. One unit is bit 9 of the count value, and a tick stands for 500 ns of time. The mode is set by an external select input, which a system-level register drives in the surrounding chip.

When the select is low the block works as a limit timer. It counts up to a programmable limit. When the count reaches the limit it sets a reached flag and raises the interrupt. Reading the limit register acknowledges the interrupt. When the select is high the same counter becomes a 64-bit free-running counter that software can start, stop and clear, and it never interrupts. Read data is registered and appears one clock after the read strobe.

Top module: `dm_limit_timer`

## Requirements
- R1: While running, each cycle with `tick_en` high advances the count by one unit (value 0x200). In limit mode a read of offset 1 returns the reached flag in bit 31, count bits 30:9 in bits 30:9, and zero in bits 8:0.
- R2: In limit mode, a write to offset 0 loads the limit from `wdata & 0x7FFFFE00`, clears the count and lowers `irq`. A masked value of zero loads 0x7FFFFE00. A write to offset 2 loads the limit in the same way but keeps the count.
- R3: In limit mode, a read of offset 0 returns the limit in bits 30:9 with the other bits zero. The same read lowers `irq` and clears the reached flag, unless the limit is reached on that same cycle. `rdata` is valid one clock after `rd_en`.
- R4: In limit mode, the tick that makes the count equal to the limit sets the reached flag and `irq`. The next tick wraps the count to zero, and `irq` stays high until it is acknowledged. A count already above a newly lowered limit wraps to zero on its next tick without raising `irq`.
- R5: In user mode, a read of offset 0 returns bits 63:32 of the 64-bit count. A read of offset 1 returns bits 31:0 with bits 8:0 zero.
- R6: In user mode, a write to offset 0 or offset 1 clears the count, lowers `irq` and sets the limit to the 63-bit maximum, whatever the write data.
- R7: In user mode, a write to offset 3 with bit 0 set starts the counter and with bit 0 clear stops it. A stopped counter ignores ticks. A read of offset 3 returns the running flag in bit 0. In limit mode, writes to offset 3 are ignored.
- R8: In user mode, `irq` stays low and the reached flag is never set.
- R9: After reset the count and the reached flag are zero, the counter runs, `irq` is low, and the limit is 0x7FFFFE00 (limit mode) or the 63-bit maximum (user mode).
- R10: Reads of offset 2 and offsets 4 to 7 return zero. Writes to offsets 4 to 7 change nothing.
- R11: A change of `user_mode` clears the count, the reached flag and `irq`, loads the reset limit of the new mode and leaves the counter running. This takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count-advance enable, one unit per cycle |
| user_mode | input | 1 | 1 selects the free-running user counter, 0 selects the limit timer |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt, level |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 9-bit sub-unit field, a 22-bit limit field and a 64-bit count. It programs small limits such as 1, 5 and 10 units, so reaching the limit, the wrap to zero and the case of a limit lowered below the count all happen within a few ticks. The upper word of the 64-bit count cannot leave zero within the run length, so R5 is checked on the lower word's contents and on the zero upper word.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  // Word offsets decoded by the register port
  localparam logic [2:0] OFS_LIMIT  = 3'd0;
  localparam logic [2:0] OFS_COUNT  = 3'd1;
  localparam logic [2:0] OFS_LKEEP  = 3'd2;
  localparam logic [2:0] OFS_RUNCTL = 3'd3;

  typedef struct packed {
    logic lim_load_rst;   // limit mode: load limit, clear count
    logic lim_load_keep;  // limit mode: load limit, keep count
    logic usr_clear;      // user mode: clear count, full limit
    logic run_write;      // user mode: start/stop
    logic ack_irq;        // limit mode: limit read acknowledges
  } dmt_cmd_t;
endpackage

// File: rtl/dmt_regdec.sv
module dmt_regdec
  import dmt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_user,
  output dmt_cmd_t          cmd
);
  always_comb begin
    cmd               = '0;
    cmd.lim_load_rst  = wr_en && (addr == OFS_LIMIT) && !mode_user;
    cmd.lim_load_keep = wr_en && (addr == OFS_LKEEP) && !mode_user;
    cmd.usr_clear     = wr_en && ((addr == OFS_LIMIT) || (addr == OFS_COUNT)) && mode_user;
    cmd.run_write     = wr_en && (addr == OFS_RUNCTL) && mode_user;
    cmd.ack_irq       = rd_en && (addr == OFS_LIMIT) && !mode_user;
  end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
  import dmt_pkg::*;
#(
  parameter int LIM_W  = 22,
  parameter int UNIT_W = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              user_mode,
  input  dmt_cmd_t          cmd,
  input  logic [LIM_W-1:0]  lim_field,
  input  logic              run_bit,
  output logic [UNIT_W-1:0] cnt_q,
  output logic [UNIT_W-1:0] lim_q,
  output logic              running_q,
  output logic              reached_q,
  output logic              irq_q,
  output logic              mode_q
);
  localparam logic [UNIT_W-1:0] LIM_MAX_LM = {{(UNIT_W-LIM_W){1'b0}}, {LIM_W{1'b1}}};
  localparam logic [UNIT_W-1:0] LIM_MAX_US = {1'b0, {(UNIT_W-1){1'b1}}};

  logic              mode_chg;
  logic              at_lim;
  logic              step;
  logic              hit;
  logic [UNIT_W-1:0] cnt_inc;
  logic [UNIT_W-1:0] lim_new;

  assign mode_chg = (user_mode != mode_q);
  assign at_lim   = (cnt_q >= lim_q);
  assign step     = running_q && tick_en;
  assign cnt_inc  = cnt_q + 1'b1;
  assign lim_new  = (lim_field == '0) ? LIM_MAX_LM : {{(UNIT_W-LIM_W){1'b0}}, lim_field};
  assign hit      = step && !at_lim && (cnt_inc == lim_q) && !mode_q && !cmd.lim_load_rst;

  always_ff @(posedge clk) begin
    if (rst || mode_chg) begin
      mode_q    <= user_mode;
      cnt_q     <= '0;
      lim_q     <= user_mode ? LIM_MAX_US : LIM_MAX_LM;
      running_q <= 1'b1;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (cmd.lim_load_rst || cmd.usr_clear)
        cnt_q <= '0;
      else if (step)
        cnt_q <= at_lim ? '0 : cnt_inc;

      if (cmd.lim_load_rst || cmd.lim_load_keep)
        lim_q <= lim_new;
      else if (cmd.usr_clear)
        lim_q <= LIM_MAX_US;

      if (cmd.run_write)
        running_q <= run_bit;

      if (hit) begin
        reached_q <= 1'b1;
        irq_q     <= 1'b1;
      end else if (cmd.ack_irq || cmd.lim_load_rst || cmd.usr_clear) begin
        reached_q <= 1'b0;
        irq_q     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dmt_readmux.sv
module dmt_readmux
  import dmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int FRAC_W = 9,
  parameter int LIM_W  = 22,
  parameter int UNIT_W = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mode_user,
  input  logic [UNIT_W-1:0] cnt_q,
  input  logic [UNIT_W-1:0] lim_q,
  input  logic              running_q,
  input  logic              reached_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int CNT_W = UNIT_W + FRAC_W;

  logic [CNT_W-1:0]  full;
  logic [DATA_W-1:0] sel;

  assign full = {cnt_q, {FRAC_W{1'b0}}};

  always_comb begin
    sel = '0;
    case (addr)
      OFS_LIMIT:
        sel = mode_user ? full[CNT_W-1 -: DATA_W]
                        : {1'b0, lim_q[LIM_W-1:0], {FRAC_W{1'b0}}};
      OFS_COUNT:
        sel = mode_user ? full[DATA_W-1:0]
                        : {reached_q, full[FRAC_W +: LIM_W], {FRAC_W{1'b0}}};
      OFS_RUNCTL:
        sel = {{(DATA_W-1){1'b0}}, running_q};
      default:
        sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= sel;
  end
endmodule

// File: rtl/dm_limit_timer.sv
module dm_limit_timer
  import dmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int FRAC_W = 9,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int LIM_W  = DATA_W - 1 - FRAC_W;
  localparam int UNIT_W = CNT_W - FRAC_W;

  dmt_cmd_t          cmd;
  logic [UNIT_W-1:0] cnt_q;
  logic [UNIT_W-1:0] lim_q;
  logic              running_q;
  logic              reached_q;
  logic              mode_q;

  dmt_regdec #(.ADDR_W(ADDR_W)) i_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .mode_user(mode_q), .cmd(cmd)
  );

  dmt_counter #(.LIM_W(LIM_W), .UNIT_W(UNIT_W)) i_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .user_mode(user_mode), .cmd(cmd),
    .lim_field(wdata[FRAC_W +: LIM_W]), .run_bit(wdata[0]),
    .cnt_q(cnt_q), .lim_q(lim_q), .running_q(running_q), .reached_q(reached_q),
    .irq_q(irq), .mode_q(mode_q)
  );

  dmt_readmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W),
                .LIM_W(LIM_W), .UNIT_W(UNIT_W)) i_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .mode_user(mode_q),
    .cnt_q(cnt_q), .lim_q(lim_q), .running_q(running_q), .reached_q(reached_q),
    .rdata(rdata)
  );
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int ADDR_W = 3,
  parameter int UNIT_W = 55
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              user_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              mode_q,
  input logic [UNIT_W-1:0] cnt_q,
  input logic [UNIT_W-1:0] lim_q,
  input logic              running_q,
  input logic              irq
);
  a_r1_tick_step: assert property (@(posedge clk) disable iff (rst)
    (running_q && tick_en && !wr_en && (user_mode == mode_q) && (cnt_q < lim_q))
      |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r2_limit_nonzero: assert property (@(posedge clk) disable iff (rst)
    lim_q != '0);

  a_r3_read_acks: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == '0) && !mode_q && (user_mode == mode_q) && !tick_en) |=> !irq);

  a_r7_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !running_q && !wr_en && (user_mode == mode_q)) |=> $stable(cnt_q));

  a_r8_user_silent: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> !irq);
endmodule

bind dm_limit_timer dmt_checker #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W)) i_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .user_mode(user_mode),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .mode_q(mode_q),
  .cnt_q(cnt_q), .lim_q(lim_q), .running_q(running_q), .irq(irq)
);

// File: tb/test_dm_limit_timer.sv
module test_dm_limit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        user_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dm_limit_timer i_dm_limit_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  // Limit mode, no ticks: write (optional) then read back
  localparam vec_t VECS [8] = '{
    '{1'b1, 3'd0, 32'h1234_5678, 3'd0, 32'h1234_5600, 8'd2},  // R2 mask
    '{1'b1, 3'd2, 32'hFFFF_FFFF, 3'd0, 32'h7FFF_FE00, 8'd2},  // R2 keep-count load
    '{1'b1, 3'd0, 32'h0000_01FF, 3'd0, 32'h7FFF_FE00, 8'd2},  // R2 zero -> max
    '{1'b1, 3'd5, 32'h0000_4000, 3'd0, 32'h7FFF_FE00, 8'd10}, // R10 write ignored
    '{1'b0, 3'd0, 32'h0,         3'd5, 32'h0,         8'd10}, // R10 unmapped read
    '{1'b0, 3'd0, 32'h0,         3'd2, 32'h0,         8'd10}, // R10 offset 2 read
    '{1'b1, 3'd3, 32'h0,         3'd3, 32'h1,         8'd7},  // R7 ignored in limit mode
    '{1'b0, 3'd0, 32'h0,         3'd1, 32'h0,         8'd1}   // R1 count zero
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq", {31'b0, irq}, 32'h0);
    rd(3'd0, v); chk("R9 limit", v, 32'h7FFF_FE00);
    rd(3'd1, v); chk("R9 count", v, 32'h0);
    rd(3'd3, v); chk("R9 running", v, 32'h1);

    foreach (VECS[k]) begin
      if (VECS[k].we) wr(VECS[k].wa, VECS[k].wd);
      rd(VECS[k].ra, v);
      chk($sformatf("R%0d vector %0d", VECS[k].rq, k), v, VECS[k].ex);
    end

    // R1/R4 counting to a limit of 5 units
    wr(3'd0, 32'h0000_0A00);
    ticks(3);
    rd(3'd1, v); chk("R1 three ticks", v, 32'h0000_0600);
    chk("R4 no irq yet", {31'b0, irq}, 32'h0);
    ticks(2);
    chk("R4 irq at limit", {31'b0, irq}, 32'h1);
    rd(3'd1, v); chk("R4 reached flag", v, 32'h8000_0A00);
    ticks(1);
    rd(3'd1, v); chk("R4 wrap keeps flag", v, 32'h8000_0000);
    chk("R4 irq held", {31'b0, irq}, 32'h1);
    rd(3'd0, v); chk("R3 limit read", v, 32'h0000_0A00);
    chk("R3 irq acked", {31'b0, irq}, 32'h0);
    rd(3'd1, v); chk("R3 flag cleared", v, 32'h0);

    // R2 load keeping count, then with reset
    ticks(2);
    wr(3'd2, 32'h0000_1400);
    rd(3'd1, v); chk("R2 count kept", v, 32'h0000_0400);
    wr(3'd0, 32'h0000_1400);
    rd(3'd1, v); chk("R2 count cleared", v, 32'h0);

    // R4 limit lowered below count
    ticks(3);
    wr(3'd2, 32'h0000_0200);
    ticks(1);
    rd(3'd1, v); chk("R4 silent wrap", v, 32'h0);
    chk("R4 silent wrap irq", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R4 irq at limit 1", {31'b0, irq}, 32'h1);

    // R11 switch to user mode
    @(negedge clk); user_mode = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 irq cleared", {31'b0, irq}, 32'h0);
    rd(3'd0, v); chk("R5 upper word", v, 32'h0);
    rd(3'd1, v); chk("R11 count zero", v, 32'h0);
    rd(3'd3, v); chk("R11 running", v, 32'h1);

    // R5/R8 user counting
    ticks(3);
    rd(3'd1, v); chk("R5 lower word", v, 32'h0000_0600);
    chk("R8 no irq", {31'b0, irq}, 32'h0);

    // R7 start/stop
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk("R7 stopped", v, 32'h0);
    ticks(4);
    rd(3'd1, v); chk("R7 hold while stopped", v, 32'h0000_0600);
    wr(3'd3, 32'hFFFF_FFFE);
    rd(3'd3, v); chk("R7 still stopped", v, 32'h0);
    wr(3'd3, 32'h1);
    ticks(1);
    rd(3'd1, v); chk("R7 restarted", v, 32'h0000_0800);
    wr(3'd3, 32'h1);
    ticks(1);
    rd(3'd1, v); chk("R7 restart no effect", v, 32'h0000_0A00);

    // R6 user clears
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, v); chk("R6 clear via 1", v, 32'h0);
    ticks(1);
    rd(3'd1, v); chk("R6 still running", v, 32'h0000_0200);
    wr(3'd0, 32'h0);
    rd(3'd1, v); chk("R6 clear via 0", v, 32'h0);
    chk("R8 irq low", {31'b0, irq}, 32'h0);

    // R11 back to limit mode
    ticks(2);
    @(negedge clk); user_mode = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(3'd0, v); chk("R11 limit reset", v, 32'h7FFF_FE00);
    rd(3'd1, v); chk("R11 count reset", v, 32'h0);
    rd(3'd3, v); chk("R11 running again", v, 32'h1);

    done = 1'b1;
    summary();
  end
endmodule